// File: doc/BRIEF.md
# Instrument Status and Service-Request Logic

This block holds the status reporting registers of a bus-controlled measuring instrument. Single-cycle event strobes are caught in a sticky eight-bit event register. An event mask decides which caught events feed a one-bit event summary. That summary and an output-queue-available level form a status byte. A second mask, the request mask, decides which status bits raise the master summary. A latched request-service bit follows the rising edge of that summary and drives the service-request line to the bus controller.

The controller reads the status byte in one of two ways. A status query returns the live master summary in bit 6 and leaves all state alone. A serial poll returns the latched request-service bit in bit 6 and clears that bit only. A clear-status command empties the event register, so the event summary drops. It leaves the queue-available bit as it is. When the command arrives just after a message terminator, the block also sends a one-cycle queue-clear pulse to the queue storage, which lives outside this block. Every read lands in a single registered read-data port one cycle after its strobe.

Top module: `status_reporter`

## Requirements
- R1: Strobing bit i of `eventStb` for one cycle sets bit i of the event register for i in {7 power-on, 5 command error, 4 execution error, 3 device-dependent error, 2 query error, 0 operation complete}. A set bit stays set until an event read or a clear-status.
- R2: Event register bits 6 and 1 always read as 0, even when `eventStb` drives them.
- R3: An `eventRead` strobe loads the event register into `readData` at the next edge and clears the register at that edge. An event strobed in the same cycle is kept.
- R4: Status bit 5 is the OR over all bits of (event register AND event mask). A mask bit of 0 keeps its event out of bit 5. `eventMaskOut` returns the stored mask.
- R5: Status bit 4 equals `queueAvail`, and a clear-status does not change it. Status bits 7 and 3..0 are 0.
- R6: The master summary is the OR over status bits 7..0, except bit 6, each ANDed with the same bit of the request mask. Request mask bit 6 is stored and read back as 0.
- R7: A `statusQuery` returns the status byte with bit 6 equal to the master summary and clears nothing.
- R8: A `serialPoll` returns the status byte with bit 6 equal to the request-service bit, and clears only that bit.
- R9: The request-service bit sets on the cycle after the master summary rises, and `srqLine` equals it. If that set coincides with a serial-poll clear, the set wins.
- R10: A `clearStatus` clears the event register, but an event strobed in the same cycle is kept. `queueClear` pulses high for one cycle, one cycle after a `clearStatus` that has `afterTerminator` high.
- R11: Reset (`rstN` low, asynchronous) zeroes both masks, `readData`, `srqLine` and `queueClear`. The power-on event bit 7 is set at the first clock edge after reset is released.
- R12: When several read strobes coincide, `readData` takes the source by priority: poll, then query, then event read. With no read strobe, `readData` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| eventStb | input | 8 | One-cycle event strobes, one per event register bit |
| queueAvail | input | 1 | Output queue holds a message |
| eventMaskWr | input | 1 | Load strobe for the event mask |
| eventMaskIn | input | 8 | New event mask value |
| reqMaskWr | input | 1 | Load strobe for the request mask |
| reqMaskIn | input | 8 | New request mask value |
| statusQuery | input | 1 | Read the status byte with the master summary |
| serialPoll | input | 1 | Read the status byte with the request-service bit, then clear that bit |
| eventRead | input | 1 | Read and clear the event register |
| clearStatus | input | 1 | Clear-status command |
| afterTerminator | input | 1 | Clear-status arrived right after a message terminator |
| readData | output | 8 | Registered result of the last read strobe |
| eventMaskOut | output | 8 | Stored event mask |
| reqMaskOut | output | 8 | Stored request mask |
| srqLine | output | 1 | Service-request line to the controller |
| queueClear | output | 1 | One-cycle pulse that empties the output queue |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a clear (by event read or by clear-status) and a new event strobe. The bench provokes it by driving both strobes in one cycle, then reads the register back; the new event must be the only bit left. The second pair is the serial-poll clear of the request-service bit and the edge at which the master summary rises. The bench strobes an event one cycle before the poll. The polled byte must show bit 6 as 0, and `srqLine` must then be high, because the set wins.

// File: rtl/status_pkg.sv
package status_pkg;
  localparam int SB_W    = 8;
  localparam int EVT_PON = 7;
  localparam int EVT_URQ = 6;
  localparam int EVT_RQC = 1;
  localparam int SB_MSS  = 6;
  localparam int SB_ESB  = 5;
  localparam int SB_MAV  = 4;

  typedef enum logic [1:0] {
    RD_HOLD,
    RD_STATUS,
    RD_POLL,
    RD_EVENT
  } readSel_e;

  typedef struct packed {
    logic     setPon;
    logic     clrEvents;
    logic     clrRqs;
    logic     loadEvtMask;
    logic     loadReqMask;
    readSel_e readSel;
  } ctrlStb_t;
endpackage

// File: rtl/status_ctrl.sv
module status_ctrl
  import status_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     statusQuery,
  input  logic     serialPoll,
  input  logic     eventRead,
  input  logic     clearStatus,
  input  logic     afterTerminator,
  input  logic     eventMaskWr,
  input  logic     reqMaskWr,
  output ctrlStb_t ctrl,
  output logic     queueClear
);
  logic ponPending;

  // ponPending is high for the first cycle after reset release only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ponPending <= 1'b1;
      queueClear <= 1'b0;
    end else begin
      ponPending <= 1'b0;
      queueClear <= clearStatus & afterTerminator;
    end
  end

  always_comb begin
    ctrl.setPon      = ponPending;
    ctrl.clrEvents   = eventRead | clearStatus;
    ctrl.clrRqs      = serialPoll;
    ctrl.loadEvtMask = eventMaskWr;
    ctrl.loadReqMask = reqMaskWr;
    // read source priority: poll, query, event read
    if (serialPoll)       ctrl.readSel = RD_POLL;
    else if (statusQuery) ctrl.readSel = RD_STATUS;
    else if (eventRead)   ctrl.readSel = RD_EVENT;
    else                  ctrl.readSel = RD_HOLD;
  end
endmodule

// File: rtl/status_datapath.sv
module status_datapath
  import status_pkg::*;
#(
  parameter int W = SB_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStb_t     ctrl,
  input  logic [W-1:0] eventStb,
  input  logic         queueAvail,
  input  logic [W-1:0] eventMaskIn,
  input  logic [W-1:0] reqMaskIn,
  output logic [W-1:0] readData,
  output logic [W-1:0] eventMaskOut,
  output logic [W-1:0] reqMaskOut,
  output logic         srqLine
);
  localparam logic [W-1:0] ONE_BIT   = W'(1);
  localparam logic [W-1:0] RESV_BITS = (ONE_BIT << EVT_URQ) | (ONE_BIT << EVT_RQC);
  localparam logic [W-1:0] PON_BIT   = ONE_BIT << EVT_PON;
  localparam logic [W-1:0] MSS_BIT   = ONE_BIT << SB_MSS;

  logic [W-1:0] evtReg, evtMask, reqMask;
  logic [W-1:0] evtSet, sumByte, queryByte, pollByte;
  logic         esb, mss, mssPrev, rqs;

  assign evtSet = eventStb | (ctrl.setPon ? PON_BIT : '0);
  assign esb    = |(evtReg & evtMask);

  always_comb begin
    sumByte         = '0;
    sumByte[SB_ESB] = esb;
    sumByte[SB_MAV] = queueAvail;
  end

  // reqMask bit 6 is stored as 0, so bit 6 never feeds itself
  assign mss       = |(sumByte & reqMask);
  assign queryByte = sumByte | (mss ? MSS_BIT : '0);
  assign pollByte  = sumByte | (rqs ? MSS_BIT : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtReg   <= '0;
      evtMask  <= '0;
      reqMask  <= '0;
      mssPrev  <= 1'b0;
      rqs      <= 1'b0;
      readData <= '0;
    end else begin
      // a new event wins over a same-cycle clear
      evtReg  <= ((ctrl.clrEvents ? '0 : evtReg) | evtSet) & ~RESV_BITS;
      mssPrev <= mss;
      // a summary rising edge wins over a same-cycle poll clear
      rqs     <= (rqs & ~ctrl.clrRqs) | (mss & ~mssPrev);
      if (ctrl.loadEvtMask) evtMask <= eventMaskIn;
      if (ctrl.loadReqMask) reqMask <= reqMaskIn & ~MSS_BIT;
      unique case (ctrl.readSel)
        RD_POLL:   readData <= pollByte;
        RD_STATUS: readData <= queryByte;
        RD_EVENT:  readData <= evtReg;
        default:   readData <= readData;
      endcase
    end
  end

  assign eventMaskOut = evtMask;
  assign reqMaskOut   = reqMask;
  assign srqLine      = rqs;
endmodule

// File: rtl/status_reporter.sv
module status_reporter
  import status_pkg::*;
#(
  parameter int W = SB_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] eventStb,
  input  logic         queueAvail,
  input  logic         eventMaskWr,
  input  logic [W-1:0] eventMaskIn,
  input  logic         reqMaskWr,
  input  logic [W-1:0] reqMaskIn,
  input  logic         statusQuery,
  input  logic         serialPoll,
  input  logic         eventRead,
  input  logic         clearStatus,
  input  logic         afterTerminator,
  output logic [W-1:0] readData,
  output logic [W-1:0] eventMaskOut,
  output logic [W-1:0] reqMaskOut,
  output logic         srqLine,
  output logic         queueClear
);
  ctrlStb_t ctrl;

  status_ctrl ctrl_i (
    .clk            (clk),
    .rstN           (rstN),
    .statusQuery    (statusQuery),
    .serialPoll     (serialPoll),
    .eventRead      (eventRead),
    .clearStatus    (clearStatus),
    .afterTerminator(afterTerminator),
    .eventMaskWr    (eventMaskWr),
    .reqMaskWr      (reqMaskWr),
    .ctrl           (ctrl),
    .queueClear     (queueClear)
  );

  status_datapath #(.W(W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .eventStb    (eventStb),
    .queueAvail  (queueAvail),
    .eventMaskIn (eventMaskIn),
    .reqMaskIn   (reqMaskIn),
    .readData    (readData),
    .eventMaskOut(eventMaskOut),
    .reqMaskOut  (reqMaskOut),
    .srqLine     (srqLine)
  );
endmodule

// File: rtl/status_reporter_chk.sv
module status_reporter_chk (
  input logic       clk,
  input logic       rstN,
  input logic       serialPoll,
  input logic       statusQuery,
  input logic       eventRead,
  input logic       clearStatus,
  input logic       afterTerminator,
  input logic       reqMaskWr,
  input logic [7:0] reqMaskIn,
  input logic [7:0] readData,
  input logic [7:0] reqMaskOut,
  input logic       srqLine,
  input logic       queueClear
);
  p_resv_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (eventRead && !serialPoll && !statusQuery) |=> (readData[6] == 1'b0 && readData[1] == 1'b0));

  p_poll_bit_r8: assert property (@(posedge clk) disable iff (!rstN)
    serialPoll |=> (readData[6] == $past(srqLine)));

  p_srq_fall_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(srqLine) |-> $past(serialPoll));

  p_qclr_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    (clearStatus && afterTerminator) |=> queueClear);

  p_qclr_src_r10: assert property (@(posedge clk) disable iff (!rstN)
    queueClear |-> $past(clearStatus && afterTerminator));

  p_reqmask_r6: assert property (@(posedge clk) disable iff (!rstN)
    reqMaskWr |=> (reqMaskOut == ($past(reqMaskIn) & 8'hBF)));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(serialPoll || statusQuery || eventRead) |=> $stable(readData));
endmodule

bind status_reporter status_reporter_chk chk_i (.*);

// File: tb/status_reporter_tb_top.sv
`timescale 1ns/1ps
module status_reporter_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] eventStb;
  logic       queueAvail;
  logic       eventMaskWr;
  logic [7:0] eventMaskIn;
  logic       reqMaskWr;
  logic [7:0] reqMaskIn;
  logic       statusQuery, serialPoll, eventRead, clearStatus, afterTerminator;
  logic [7:0] readData, eventMaskOut, reqMaskOut;
  logic       srqLine, queueClear;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  status_reporter dut_i (
    .clk(clk), .rstN(rstN), .eventStb(eventStb), .queueAvail(queueAvail),
    .eventMaskWr(eventMaskWr), .eventMaskIn(eventMaskIn),
    .reqMaskWr(reqMaskWr), .reqMaskIn(reqMaskIn),
    .statusQuery(statusQuery), .serialPoll(serialPoll), .eventRead(eventRead),
    .clearStatus(clearStatus), .afterTerminator(afterTerminator),
    .readData(readData), .eventMaskOut(eventMaskOut), .reqMaskOut(reqMaskOut),
    .srqLine(srqLine), .queueClear(queueClear)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one clock edge, then drop all strobes; returns at the following negedge
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    eventStb = '0; eventMaskWr = 0; reqMaskWr = 0; statusQuery = 0;
    serialPoll = 0; eventRead = 0; clearStatus = 0; afterTerminator = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 0; eventStb = '0; queueAvail = 0; eventMaskWr = 0; eventMaskIn = '0;
    reqMaskWr = 0; reqMaskIn = '0; statusQuery = 0; serialPoll = 0;
    eventRead = 0; clearStatus = 0; afterTerminator = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 readData", readData, 8'h00);
    chk("R11 srqLine", {7'b0, srqLine}, 8'h00);
    chk("R11 eventMask", eventMaskOut, 8'h00);
    chk("R11 reqMask", reqMaskOut, 8'h00);
    chk("R11 queueClear", {7'b0, queueClear}, 8'h00);
    rstN = 1;
    cyc();
    eventRead = 1; cyc();
    chk("R11 power-on bit", readData, 8'h80);
    eventRead = 1; cyc();
    chk("R3 cleared by read", readData, 8'h00);

    // R2 reserved bits
    eventStb = 8'hFF; cyc();
    eventRead = 1; cyc();
    chk("R2 reserved bits zero", readData, 8'hBD);

    // R3 read and new event in the same cycle
    eventStb = 8'h04; cyc();
    eventRead = 1; eventStb = 8'h20; cyc();
    chk("R3 read old value", readData, 8'h04);
    eventRead = 1; cyc();
    chk("R3 same-cycle event kept", readData, 8'h20);

    // R1 stickiness
    eventStb = 8'h01; cyc(); cyc(); cyc();
    eventStb = 8'h10; cyc();
    eventRead = 1; cyc();
    chk("R1 sticky events", readData, 8'h11);

    // R4 / R10 sweep over every event mask
    for (int m = 0; m < 256; m++) begin
      logic [7:0] mv, pv, ev;
      mv = 8'(m);
      pv = 8'(m * 37 + 11);
      queueAvail = mv[0];
      eventMaskWr = 1; eventMaskIn = mv; clearStatus = 1; eventStb = pv;
      cyc();
      statusQuery = 1; cyc();
      ev = {2'b00, |(pv & mv & 8'hBD), mv[0], 4'b0000};
      chk("R4 event summary sweep", readData, ev);
      if (m % 32 == 5) chk("R4 event mask readback", eventMaskOut, mv);
    end

    // R5 queue bit survives clear-status
    queueAvail = 1; clearStatus = 1; cyc();
    statusQuery = 1; cyc();
    chk("R5 queue bit after clear", readData, 8'h10);

    // R6 / R7 sweep over every request mask, both queue levels
    eventMaskWr = 1; eventMaskIn = 8'hFF; eventStb = 8'h01; cyc();
    for (int r = 0; r < 256; r++) begin
      for (int q = 0; q < 2; q++) begin
        logic [7:0] rv, ev;
        logic mssExp;
        rv = 8'(r);
        queueAvail = q[0];
        reqMaskWr = 1; reqMaskIn = rv; cyc();
        statusQuery = 1; cyc();
        mssExp = rv[5] | (rv[4] & q[0]);
        ev = {1'b0, mssExp, 1'b1, q[0], 4'b0000};
        chk("R7 query master summary sweep", readData, ev);
        chk("R6 request mask readback", reqMaskOut, rv & 8'hBF);
      end
    end
    eventRead = 1; cyc();
    chk("R7 query cleared nothing", readData, 8'h01);

    // R8 / R9 request bit
    queueAvail = 0; reqMaskWr = 1; reqMaskIn = 8'h00; clearStatus = 1; cyc();
    serialPoll = 1; cyc();
    chk("R8 poll cleared request", {7'b0, srqLine}, 8'h00);
    reqMaskWr = 1; reqMaskIn = 8'h20; cyc();
    eventStb = 8'h20; cyc();
    chk("R9 no request before edge", {7'b0, srqLine}, 8'h00);
    cyc();
    chk("R9 request after rise", {7'b0, srqLine}, 8'h01);
    statusQuery = 1; cyc();
    chk("R7 query shows summary", readData, 8'h60);
    chk("R7 query keeps request", {7'b0, srqLine}, 8'h01);
    serialPoll = 1; cyc();
    chk("R8 poll shows request", readData, 8'h60);
    chk("R8 poll clears line", {7'b0, srqLine}, 8'h00);
    serialPoll = 1; cyc();
    chk("R8 poll bit is request not summary", readData, 8'h20);
    statusQuery = 1; cyc();
    chk("R8 summary still set", readData, 8'h60);

    // R9 rise and poll clear in the same cycle
    clearStatus = 1; cyc();
    cyc();
    eventStb = 8'h20; cyc();
    serialPoll = 1; cyc();
    chk("R9 poll at rise reads old bit", readData, 8'h20);
    chk("R9 set wins over poll clear", {7'b0, srqLine}, 8'h01);

    // R10 queue clear pulse
    clearStatus = 1; afterTerminator = 1; cyc();
    chk("R10 queueClear pulse", {7'b0, queueClear}, 8'h01);
    cyc();
    chk("R10 queueClear one cycle", {7'b0, queueClear}, 8'h00);
    clearStatus = 1; cyc();
    chk("R10 no pulse without terminator", {7'b0, queueClear}, 8'h00);
    eventStb = 8'h08; clearStatus = 1; cyc();
    eventRead = 1; cyc();
    chk("R10 same-cycle event kept", readData, 8'h08);

    // R12 read priority and hold
    clearStatus = 1; cyc();
    serialPoll = 1; cyc();
    queueAvail = 1;
    eventStb = 8'h04; cyc();
    serialPoll = 1; statusQuery = 1; eventRead = 1; cyc();
    chk("R12 poll has priority", readData, 8'h30);
    cyc();
    chk("R12 readData holds", readData, 8'h30);
    statusQuery = 1; cyc();
    chk("R3 event read applied under priority", readData, 8'h10);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule